// File: doc/BRIEF.md
# Receive Pattern Sync Monitor

This block sits behind a test-pattern comparator on a serial receive path. On each enabled bit slot it takes the received data bit and the comparator's error flag for that bit. It tracks whether the receiver is locked to the expected pattern, and it flags long runs of all-ones and all-zeros on the line. While locked, it counts received bits and errored bits, and it pulses an event when either counter wraps. It also keeps the last 32 received bits so they can be read one byte at a time.

Lock is gained after a run of error-free bits. It is lost when too many of the recent in-lock bits were errored, measured over a sliding window. A control input can hold the lock so that errors never drop it, which is used for error-count testing. The outputs are the live levels and the one-cycle event strobes that a status register above this block latches.

Top module: `rx_pattern_monitor`

## Requirements
- R1: `allOnes` goes high in the cycle after the 32nd consecutive enabled bit with `rxBit`=1. It stays high while more 1s arrive and falls after the first enabled 0.
- R2: `allZeros` goes high in the cycle after the 32nd consecutive enabled bit with `rxBit`=0, and falls after the first enabled 1. It is never high together with `allOnes`.
- R3: While searching (`inSync`=0, `searching`=1), 32 consecutive enabled bits with `errBit`=0 declare sync. An errored bit restarts that run.
- R4: While in sync with `holdSync`=0, the block drops to searching on the enabled bit that brings the errored count among the last 64 in-sync bits to 6 or more. Errors that have left the window no longer count, and the window is cleared when sync is declared.
- R5: With `holdSync`=1, errored bits never drop sync.
- R6: `bitErrEvt` pulses for one cycle after each enabled errored bit received while in sync. Errored bits received while searching raise no pulse.
- R7: `bitCount` counts enabled bits received while in sync, and `errCount` counts the errored ones among them. Both hold their value while searching.
- R8: Both counters are CNT_W bits wide (32 by default) and wrap to zero. `bitCntWrap` and `errCntWrap` each pulse for one cycle on the wrap of their counter.
- R9: The last 32 enabled `rxBit` values are kept, with the newest in bit 0. `byteSel`=0 reads bits 31:24, 1 reads 23:16, 2 reads 15:8 and 3 reads 7:0 on `patByte`.
- R10: A cycle with `bitEn`=0 changes no state, whatever `rxBit` and `errBit` carry.
- R11: After reset the block is searching, both run levels are low, both counters are zero and the kept pattern is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | One received bit is valid this cycle |
| rxBit | input | 1 | Received data bit |
| errBit | input | 1 | Comparator reports this bit in error |
| holdSync | input | 1 | 1 stops the window criterion from dropping sync |
| byteSel | input | SEL_W | Selects a byte of the kept pattern |
| inSync | output | 1 | Live sync level |
| searching | output | 1 | High while sync is not held |
| allOnes | output | 1 | Long all-ones run level |
| allZeros | output | 1 | Long all-zeros run level |
| bitErrEvt | output | 1 | Errored bit seen in sync, one-cycle pulse |
| bitCntWrap | output | 1 | Bit counter wrapped, one-cycle pulse |
| errCntWrap | output | 1 | Error counter wrapped, one-cycle pulse |
| bitCount | output | CNT_W | Received-bit count |
| errCount | output | CNT_W | Errored-bit count |
| patByte | output | 8 | Selected byte of the kept pattern |

## Verification
Sync is tried with four error patterns. A clean run broken by an error at bit 32 shows that the acquisition run restarts. Six back-to-back errors separate the five-error case, which must keep sync, from the sixth error, which must drop it. Five errors followed by 59 clean bits and a further error show that errors leave the window. One error right after re-acquisition shows that the window was cleared when sync was declared. The run detectors get 31 versus 32 equal bits with disabled cycles of the opposite value in between. The counters use a reduced width so that the wrap pulses can be reached.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;
  typedef struct packed {
    logic tick;      // a bit slot is valid
    logic countBit;  // bit received while in sync
    logic countErr;  // errored bit received while in sync
    logic clearWin;  // sync declared: empty the error window
  } ctlStrobe_t;
endpackage

// File: rtl/rxmon_ctrl.sv
module rxmon_ctrl #(
  parameter int SYNC_LEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bitEn,
  input  logic                    errBit,
  input  logic                    holdSync,
  input  logic                    lossHit,
  output rxmon_pkg::ctlStrobe_t   stb,
  output logic                    inSync
);
  localparam int GW = $clog2(SYNC_LEN);

  logic [GW-1:0] goodRun;
  logic declare, drop;

  always_comb begin
    stb.tick     = bitEn;
    stb.countBit = bitEn && inSync;
    stb.countErr = bitEn && inSync && errBit;
    declare      = bitEn && !inSync && !errBit && (goodRun == GW'(SYNC_LEN - 1));
    stb.clearWin = declare;
    drop         = stb.countBit && lossHit && !holdSync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inSync  <= 1'b0;
      goodRun <= '0;
    end else if (bitEn) begin
      if (!inSync) begin
        if (declare) begin
          inSync  <= 1'b1;
          goodRun <= '0;
        end else if (errBit) begin
          goodRun <= '0;
        end else begin
          goodRun <= goodRun + 1'b1;
        end
      end else if (drop) begin
        inSync <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxmon_dp.sv
module rxmon_dp #(
  parameter int PAT_W    = 32,
  parameter int RUN_LEN  = 32,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_THR = 6,
  parameter int CNT_W    = 32,
  parameter int SEL_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rxmon_pkg::ctlStrobe_t stb,
  input  logic                  rxBit,
  input  logic                  errBit,
  input  logic [SEL_W-1:0]      byteSel,
  output logic                  lossHit,
  output logic                  allOnes,
  output logic                  allZeros,
  output logic [7:0]            patByte,
  output logic [CNT_W-1:0]      bitCount,
  output logic [CNT_W-1:0]      errCount,
  output logic                  bitCntWrap,
  output logic                  errCntWrap,
  output logic                  bitErrEvt
);
  localparam int RUN_W  = $clog2(RUN_LEN + 1);
  localparam int WIN_CW = $clog2(WIN_LEN + 1);
  localparam int NBYTES = PAT_W / 8;

  // run detectors: index 0 watches zeros, index 1 watches ones
  logic [1:0] runHit;
  for (genvar g = 0; g < 2; g++) begin : g_run
    logic [RUN_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (stb.tick) begin
        if (rxBit == 1'(g)) begin
          if (cnt != RUN_W'(RUN_LEN)) cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
        end
      end
    end
    assign runHit[g] = (cnt == RUN_W'(RUN_LEN));
  end
  assign allZeros = runHit[0];
  assign allOnes  = runHit[1];

  // kept pattern, newest bit at bit 0
  logic [PAT_W-1:0] patReg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) patReg <= '0;
    else if (stb.tick) patReg <= {patReg[PAT_W-2:0], rxBit};
  end

  logic [7:0] byteArr [NBYTES];
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byteArr[b] = patReg[PAT_W-1-8*b -: 8];
  end
  assign patByte = byteArr[byteSel];

  // sliding error window with running count
  logic [WIN_LEN-1:0] winReg;
  logic [WIN_CW-1:0]  winCnt, winNext;
  assign winNext = winCnt + {{(WIN_CW-1){1'b0}}, errBit}
                          - {{(WIN_CW-1){1'b0}}, winReg[WIN_LEN-1]};
  assign lossHit = (winNext >= WIN_CW'(LOSS_THR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winReg <= '0;
      winCnt <= '0;
    end else if (stb.clearWin) begin
      winReg <= '0;
      winCnt <= '0;
    end else if (stb.countBit) begin
      winReg <= {winReg[WIN_LEN-2:0], errBit};
      winCnt <= winNext;
    end
  end

  // wrapping counters and event strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCount   <= '0;
      errCount   <= '0;
      bitCntWrap <= 1'b0;
      errCntWrap <= 1'b0;
      bitErrEvt  <= 1'b0;
    end else begin
      bitCntWrap <= stb.countBit && (&bitCount);
      errCntWrap <= stb.countErr && (&errCount);
      bitErrEvt  <= stb.countErr;
      if (stb.countBit) bitCount <= bitCount + 1'b1;
      if (stb.countErr) errCount <= errCount + 1'b1;
    end
  end
endmodule

// File: rtl/rx_pattern_monitor.sv
module rx_pattern_monitor #(
  parameter int PAT_W    = 32,
  parameter int RUN_LEN  = 32,
  parameter int SYNC_LEN = 32,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_THR = 6,
  parameter int CNT_W    = 32,
  localparam int SEL_W   = $clog2(PAT_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitEn,
  input  logic             rxBit,
  input  logic             errBit,
  input  logic             holdSync,
  input  logic [SEL_W-1:0] byteSel,
  output logic             inSync,
  output logic             searching,
  output logic             allOnes,
  output logic             allZeros,
  output logic             bitErrEvt,
  output logic             bitCntWrap,
  output logic             errCntWrap,
  output logic [CNT_W-1:0] bitCount,
  output logic [CNT_W-1:0] errCount,
  output logic [7:0]       patByte
);
  rxmon_pkg::ctlStrobe_t stb;
  logic lossHit;

  rxmon_ctrl #(.SYNC_LEN(SYNC_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .errBit(errBit),
    .holdSync(holdSync), .lossHit(lossHit), .stb(stb), .inSync(inSync)
  );

  rxmon_dp #(
    .PAT_W(PAT_W), .RUN_LEN(RUN_LEN), .WIN_LEN(WIN_LEN),
    .LOSS_THR(LOSS_THR), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rxBit(rxBit), .errBit(errBit),
    .byteSel(byteSel), .lossHit(lossHit), .allOnes(allOnes),
    .allZeros(allZeros), .patByte(patByte), .bitCount(bitCount),
    .errCount(errCount), .bitCntWrap(bitCntWrap), .errCntWrap(errCntWrap),
    .bitErrEvt(bitErrEvt)
  );

  assign searching = !inSync;
endmodule

// File: rtl/rx_pattern_monitor_chk.sv
module rx_pattern_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bitEn,
  input logic             rxBit,
  input logic             errBit,
  input logic             holdSync,
  input logic             inSync,
  input logic             allOnes,
  input logic             allZeros,
  input logic             bitErrEvt,
  input logic             bitCntWrap,
  input logic [CNT_W-1:0] bitCount
);
  a_r1_ones_clear: assert property (@(posedge clk) disable iff (!rst_n)
    allOnes && bitEn && !rxBit |=> !allOnes);

  a_r2_zeros_clear: assert property (@(posedge clk) disable iff (!rst_n)
    allZeros && bitEn && rxBit |=> !allZeros);

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(allOnes && allZeros));

  a_r5_hold_keeps_sync: assert property (@(posedge clk) disable iff (!rst_n)
    inSync && holdSync && bitEn |=> inSync);

  a_r6_evt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bitErrEvt |-> $past(inSync && bitEn && errBit));

  a_r7_frozen_search: assert property (@(posedge clk) disable iff (!rst_n)
    !inSync |=> $stable(bitCount));

  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bitCntWrap |-> bitCount == '0);
endmodule

bind rx_pattern_monitor rx_pattern_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .rxBit(rxBit), .errBit(errBit),
  .holdSync(holdSync), .inSync(inSync), .allOnes(allOnes),
  .allZeros(allZeros), .bitErrEvt(bitErrEvt), .bitCntWrap(bitCntWrap),
  .bitCount(bitCount)
);

// File: tb/sim_rx_pattern_monitor.sv
module sim_rx_pattern_monitor;
  localparam int CW = 10;  // reduced counter width so wraps are reachable

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitEn = 1'b0, rxBit = 1'b0, errBit = 1'b0, holdSync = 1'b0;
  logic [1:0] byteSel = 2'd0;
  logic inSync, searching, allOnes, allZeros, bitErrEvt, bitCntWrap, errCntWrap;
  logic [CW-1:0] bitCount, errCount;
  logic [7:0] patByte;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_pattern_monitor #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .rxBit(rxBit), .errBit(errBit),
    .holdSync(holdSync), .byteSel(byteSel), .inSync(inSync),
    .searching(searching), .allOnes(allOnes), .allZeros(allZeros),
    .bitErrEvt(bitErrEvt), .bitCntWrap(bitCntWrap), .errCntWrap(errCntWrap),
    .bitCount(bitCount), .errCount(errCount), .patByte(patByte)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one enabled bit, sampled just after the edge that consumes it
  task automatic sendBit(input logic d, input logic e);
    @(negedge clk);
    bitEn = 1'b1; rxBit = d; errBit = e;
    @(posedge clk);
    #1;
    bitEn = 1'b0;
  endtask

  task automatic idle(input int n, input logic d, input logic e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitEn = 1'b0; rxBit = d; errBit = e;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic doReset(input logic hold);
    @(negedge clk);
    rst_n = 1'b0; bitEn = 1'b0; rxBit = 1'b0; errBit = 1'b0; holdSync = hold;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic acquire();
    for (int i = 0; i < 32; i++) sendBit(i[0], 1'b0);
  endtask

  task automatic t_reset();
    doReset(1'b0);
    #1;
    chk("R11 inSync", inSync, 0);
    chk("R11 searching", searching, 1);
    chk("R11 allOnes", allOnes, 0);
    chk("R11 allZeros", allZeros, 0);
    chk("R11 bitCount", bitCount, 0);
    chk("R11 errCount", errCount, 0);
    byteSel = 2'd0; #1;
    chk("R11 pattern", patByte, 0);
  endtask

  task automatic t_acquire();
    doReset(1'b0);
    for (int i = 0; i < 31; i++) sendBit(1'b1, 1'b0);
    chk("R3 not yet after 31", inSync, 0);
    sendBit(1'b0, 1'b1);
    chk("R3 error restarts", inSync, 0);
    chk("R6 no event while searching", bitErrEvt, 0);
    for (int i = 0; i < 31; i++) sendBit(1'b0, 1'b0);
    chk("R3 still searching", searching, 1);
    sendBit(1'b1, 1'b0);
    chk("R3 sync declared", inSync, 1);
    chk("R3 searching low", searching, 0);
    chk("R7 nothing counted while searching", bitCount, 0);
  endtask

  task automatic t_runs();
    doReset(1'b0);
    for (int i = 0; i < 31; i++) sendBit(1'b1, 1'b0);
    chk("R1 31 ones", allOnes, 0);
    idle(3, 1'b0, 1'b1);
    chk("R10 disabled zeros ignored", allOnes, 0);
    sendBit(1'b1, 1'b0);
    chk("R1 32 ones", allOnes, 1);
    sendBit(1'b1, 1'b0);
    chk("R1 stays high", allOnes, 1);
    sendBit(1'b0, 1'b0);
    chk("R1 cleared by 0", allOnes, 0);
    for (int i = 0; i < 30; i++) sendBit(1'b0, 1'b0);
    chk("R2 31 zeros", allZeros, 0);
    sendBit(1'b0, 1'b0);
    chk("R2 32 zeros", allZeros, 1);
    chk("R2 ones low", allOnes, 0);
    sendBit(1'b1, 1'b0);
    chk("R2 cleared by 1", allZeros, 0);
  endtask

  task automatic t_pattern();
    logic [31:0] pat = 32'hA5C3_0F96;
    doReset(1'b0);
    for (int i = 31; i >= 0; i--) sendBit(pat[i], 1'b0);
    for (int b = 0; b < 4; b++) begin
      byteSel = 2'(b); #1;
      chk("R9 byte", patByte, pat[31-8*b -: 8]);
    end
    sendBit(1'b1, 1'b0);
    byteSel = 2'd0; #1;
    chk("R9 shifted top byte", patByte, 8'h4B);
    byteSel = 2'd3; #1;
    chk("R9 shifted low byte", patByte, 8'h2D);
  endtask

  task automatic t_errEvt();
    doReset(1'b0);
    acquire();
    for (int i = 0; i < 3; i++) sendBit(1'b1, 1'b0);
    chk("R7 bit count", bitCount, 3);
    sendBit(1'b1, 1'b1);
    chk("R6 event", bitErrEvt, 1);
    chk("R7 err count", errCount, 1);
    chk("R7 bit count incl error", bitCount, 4);
    sendBit(1'b1, 1'b0);
    chk("R6 one cycle", bitErrEvt, 0);
    idle(2, 1'b1, 1'b1);
    chk("R10 disabled error ignored", errCount, 1);
  endtask

  task automatic t_loss();
    doReset(1'b0);
    acquire();
    for (int i = 0; i < 5; i++) sendBit(1'b0, 1'b1);
    chk("R4 five errors keep sync", inSync, 1);
    sendBit(1'b0, 1'b1);
    chk("R4 sixth error drops", inSync, 0);
    chk("R4 searching", searching, 1);
    chk("R7 bits incl dropping bit", bitCount, 6);
    chk("R7 errs incl dropping bit", errCount, 6);
    for (int i = 0; i < 3; i++) sendBit(1'b0, 1'b0);
    chk("R7 frozen while searching", bitCount, 6);
    acquire();
    chk("R3 resync", inSync, 1);
    sendBit(1'b0, 1'b1);
    chk("R4 window cleared on declare", inSync, 1);
  endtask

  task automatic t_slide();
    doReset(1'b0);
    acquire();
    for (int i = 0; i < 5; i++) sendBit(1'b1, 1'b1);
    for (int i = 0; i < 59; i++) sendBit(1'b1, 1'b0);
    sendBit(1'b1, 1'b1);
    chk("R4 oldest error left window", inSync, 1);
    chk("R7 err count", errCount, 6);
  endtask

  task automatic t_hold();
    doReset(1'b1);
    acquire();
    for (int i = 0; i < 10; i++) sendBit(1'b0, 1'b1);
    chk("R5 hold keeps sync", inSync, 1);
    chk("R7 errs under hold", errCount, 10);
  endtask

  task automatic t_wrap();
    int seen = 0;
    doReset(1'b1);
    acquire();
    for (int i = 0; i < 1023; i++) begin
      sendBit(1'b1, 1'b1);
      if (bitCntWrap || errCntWrap) seen++;
    end
    chk("R8 no early wrap", seen, 0);
    chk("R8 bit count at max", bitCount, 1023);
    sendBit(1'b1, 1'b1);
    chk("R8 bit wrap pulse", bitCntWrap, 1);
    chk("R8 err wrap pulse", errCntWrap, 1);
    chk("R8 bit count zero", bitCount, 0);
    chk("R8 err count zero", errCount, 0);
    sendBit(1'b1, 1'b0);
    chk("R8 bit pulse one cycle", bitCntWrap, 0);
    chk("R8 err pulse one cycle", errCntWrap, 0);
    chk("R8 counts on after wrap", bitCount, 1);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_runs();
    t_pattern();
    t_errEvt();
    t_loss();
    t_slide();
    t_hold();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule